// File: doc/BRIEF.md
# Daisy-Chained Front-End Readout Sequencer

This block runs one acquisition frame for a board of chained front-end chips. Each chip has sixteen channels, and each channel holds an energy amplitude and a time amplitude. The chips combine all of their channel hit flags into one OR-ed request line. When that request arrives while the block is idle, the block marks itself busy and raises the hold strobe after a fixed delay. The rising edge of the hold strobe freezes the energy track-and-hold in every channel. A configurable number of cycles later, the block issues a single common stop pulse that ends every running time-to-amplitude conversion. The length of that wait is picked by a static range input, so the stop always lands inside the converter range that is selected.

The block then walks the chain one chip at a time. Inside a chip it takes the channels in ascending order, and for each channel it takes the energy value first and the time value second. Every value gets a fixed-length slot, during which a chip/channel/kind tag drives the analog sample select. In the last cycle of the slot, the tag is offered on a valid/ready handshake. A cycle counter measures the readout against a total budget and raises a sticky overrun flag if the budget is exceeded. After the final value is accepted, the block releases the hold, pulses the chip reset, and returns to idle.

Top module: `fe_readout_seq`

## Requirements
- R1: After reset, busy, hold, stop, sample valid, chip reset and overrun are all low.
- R2: When the request is sampled high while idle, busy is high from the next cycle. The hold output rises exactly HOLD_DLY clock edges after the edge that sampled the request, and hold is never high while busy is low.
- R3: The stop output is a single-cycle pulse and occurs once per frame. Its edge comes STOP_SHORT_CYC edges after the hold rises when the range input is 0, and STOP_LONG_CYC edges after when it is 1.
- R4: Values are offered for chip 0 up to chip N_CHIPS-1. Within a chip, channels go from 0 up to N_CH-1. Each channel gives energy (kind bit 0) and then time (kind bit 1).
- R5: The first slot starts in the cycle the stop pulse is high. Every slot lasts SLOT_CYC cycles, and valid is raised in the last cycle of the slot. The next slot starts in the cycle after an accept (valid and ready both high).
- R6: While valid is high and ready is low, valid stays high and the chip, channel and kind outputs hold their values.
- R7: If the readout phase lasts more than BUDGET_CYC cycles, the overrun output goes high. It stays high until the next accepted request clears it. A readout of BUDGET_CYC cycles or fewer leaves it low.
- R8: The edge that accepts the final value drops hold. The chip reset output is then high for exactly RST_CYC cycles, and busy falls in the cycle after that.
- R9: A request asserted while busy is ignored. It adds no stop pulse and no value, and it does not start a new frame once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hit_req_i | input | 1 | OR of all channel hit requests |
| range_long_i | input | 1 | Converter range select: 0 short, 1 long |
| busy_o | output | 1 | High from the accepted request until the frame ends |
| hold_o | output | 1 | Track-and-hold freeze strobe |
| stop_o | output | 1 | Common conversion stop pulse |
| smp_valid_o | output | 1 | Current value offered |
| smp_ready_i | input | 1 | Consumer accepts the value |
| smp_chip_o | output | CHIP_W | Chip index of the current value |
| smp_chan_o | output | CHAN_W | Channel index of the current value |
| smp_time_o | output | 1 | Kind: 0 energy, 1 time |
| chip_rst_o | output | 1 | Reset pulse to the chips after readout |
| overrun_o | output | 1 | Sticky readout budget overrun flag |

## Verification
Each frame runs under one of several patterns.
- A frame with ready always on and the short range shows the base timing of hold, stop and slots, and the scan order.
- A frame with the long range tells the two stop delays apart.
- Two frames stall only the final value, one for exactly enough cycles to fill the budget and one for a single cycle more. Together they separate "at the budget" from "over the budget", and the follow-up frame shows that the flag clears only on a new request.
- A frame that holds the request high all through readout shows that a request during busy adds no stop, no value and no new frame.

// File: rtl/fe_readout_seq.sv
module fe_readout_seq #(
  parameter int N_CHIPS        = 9,
  parameter int N_CH           = 16,
  parameter int SLOT_CYC       = 36,
  parameter int BUDGET_CYC     = 20000,
  parameter int HOLD_DLY       = 4,
  parameter int STOP_SHORT_CYC = 60,
  parameter int STOP_LONG_CYC  = 130,
  parameter int RST_CYC        = 8,
  localparam int CHIP_W = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1,
  localparam int CHAN_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_req_i,
  input  logic              range_long_i,
  output logic              busy_o,
  output logic              hold_o,
  output logic              stop_o,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [CHIP_W-1:0] smp_chip_o,
  output logic [CHAN_W-1:0] smp_chan_o,
  output logic              smp_time_o,
  output logic              chip_rst_o,
  output logic              overrun_o
);

  localparam int M1   = (HOLD_DLY > SLOT_CYC) ? HOLD_DLY : SLOT_CYC;
  localparam int M2   = (STOP_LONG_CYC > STOP_SHORT_CYC) ? STOP_LONG_CYC : STOP_SHORT_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int CMAX = (M3 > RST_CYC) ? M3 : RST_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(BUDGET_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_CONV, S_READ, S_CRST} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bud;

  logic [CW-1:0] stop_lim;
  logic          slot_end, accept, last_val;

  assign stop_lim    = range_long_i ? CW'(STOP_LONG_CYC - 1) : CW'(STOP_SHORT_CYC - 1);
  assign slot_end    = (cnt == CW'(SLOT_CYC - 1));
  assign smp_valid_o = (st == S_READ) && slot_end;
  assign accept      = smp_valid_o && smp_ready_i;
  assign last_val    = (smp_chip_o == CHIP_W'(N_CHIPS - 1)) &&
                       (smp_chan_o == CHAN_W'(N_CH - 1)) && smp_time_o;
  assign busy_o      = (st != S_IDLE);
  assign chip_rst_o  = (st == S_CRST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bud        <= '0;
      hold_o     <= 1'b0;
      stop_o     <= 1'b0;
      overrun_o  <= 1'b0;
      smp_chip_o <= '0;
      smp_chan_o <= '0;
      smp_time_o <= 1'b0;
    end else begin
      stop_o <= 1'b0;
      case (st)
        S_IDLE: if (hit_req_i) begin
          st        <= S_ARM;
          cnt       <= '0;
          overrun_o <= 1'b0;
        end
        S_ARM: if (cnt == CW'(HOLD_DLY - 1)) begin
          st     <= S_CONV;
          cnt    <= '0;
          hold_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_CONV: if (cnt == stop_lim) begin
          st         <= S_READ;
          cnt        <= '0;
          bud        <= '0;
          stop_o     <= 1'b1;
          smp_chip_o <= '0;
          smp_chan_o <= '0;
          smp_time_o <= 1'b0;
        end else cnt <= cnt + 1'b1;
        S_READ: begin
          if (bud == BW'(BUDGET_CYC)) overrun_o <= 1'b1;
          else bud <= bud + 1'b1;
          if (accept) begin
            cnt <= '0;
            if (last_val) begin
              st     <= S_CRST;
              hold_o <= 1'b0;
            end else if (!smp_time_o) begin
              smp_time_o <= 1'b1;
            end else begin
              smp_time_o <= 1'b0;
              if (smp_chan_o == CHAN_W'(N_CH - 1)) begin
                smp_chan_o <= '0;
                smp_chip_o <= smp_chip_o + 1'b1;
              end else smp_chan_o <= smp_chan_o + 1'b1;
            end
          end else if (!slot_end) cnt <= cnt + 1'b1;
        end
        S_CRST: if (cnt == CW'(RST_CYC - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> busy_o);

  p_stop_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);

  p_energy_then_time_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !smp_time_o) |=> (smp_time_o && $stable(smp_chip_o) && $stable(smp_chan_o)));

  p_valid_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=>
      (smp_valid_o && $stable(smp_chip_o) && $stable(smp_chan_o) && $stable(smp_time_o)));

  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && busy_o) |=> overrun_o);

  p_rst_after_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> chip_rst_o);

endmodule

// File: tb/fe_readout_seq_tb_top.sv
module fe_readout_seq_tb_top;
  localparam int NCHIP = 3, NCH = 4, SLOT = 3, BUDGET = 80;
  localparam int HDLY = 2, SSH = 5, SLG = 9, RSTC = 2;
  localparam int NVAL = NCHIP * NCH * 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit_req = 1'b0, range_long = 1'b0, ready = 1'b0;
  logic busy, hold, stop, valid, tkind, crst, ovr;
  logic [1:0] chip, chan;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fe_readout_seq #(.N_CHIPS(NCHIP), .N_CH(NCH), .SLOT_CYC(SLOT), .BUDGET_CYC(BUDGET),
    .HOLD_DLY(HDLY), .STOP_SHORT_CYC(SSH), .STOP_LONG_CYC(SLG), .RST_CYC(RSTC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hit_req_i(hit_req), .range_long_i(range_long),
    .busy_o(busy), .hold_o(hold), .stop_o(stop), .smp_valid_o(valid), .smp_ready_i(ready),
    .smp_chip_o(chip), .smp_chan_o(chan), .smp_time_o(tkind), .chip_rst_o(crst),
    .overrun_o(ovr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !stop && !valid && !crst && !ovr, "R1 reset outputs",
        {busy, hold, stop, valid, crst, ovr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input bit lng, input int stall_idx, input int stall_len,
                           input bit noise, input bit exp_ovr);
    int w, extra_stop;
    range_long = lng;
    @(negedge clk); hit_req = 1'b1;
    @(negedge clk); hit_req = noise;
    chk(busy == 1'b1, "R2 busy after request", busy, 1);
    chk(ovr == 1'b0, "R7 overrun cleared by request", ovr, 0);
    w = 0;
    while (!hold) begin @(negedge clk); w++; end
    chk(w == HDLY, "R2 hold delay", w, HDLY);
    w = 0;
    while (!stop) begin @(negedge clk); w++; end
    chk(w == (lng ? SLG : SSH), "R3 stop delay for range", w, lng ? SLG : SSH);
    extra_stop = 0;
    for (int v = 0; v < NVAL; v++) begin
      logic [1:0] e_chip, e_chan;
      logic e_kind;
      int s;
      e_chip = 2'(v / (2 * NCH));
      e_chan = 2'((v / 2) % NCH);
      e_kind = v[0];
      w = 0;
      while (!valid) begin
        @(negedge clk); w++;
        if (stop) extra_stop++;
      end
      chk(w == SLOT - 1, "R5 slot length", w, SLOT - 1);
      chk(chip == e_chip && chan == e_chan && tkind == e_kind, "R4 scan order",
          {chip, chan, tkind}, {e_chip, e_chan, e_kind});
      s = (v == stall_idx) ? stall_len : 0;
      for (int k = 0; k < s; k++) begin
        @(negedge clk);
        if (stop) extra_stop++;
        chk(valid && chip == e_chip && chan == e_chan && tkind == e_kind,
            "R6 hold under backpressure", {valid, chip, chan, tkind},
            {1'b1, e_chip, e_chan, e_kind});
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      if (stop) extra_stop++;
    end
    hit_req = 1'b0;
    chk(extra_stop == 0, "R9 no extra stop pulse", extra_stop, 0);
    chk(crst && !hold && busy, "R8 hold drop and chip reset", {crst, hold, busy}, 3'b101);
    w = 1;
    @(negedge clk);
    while (crst) begin @(negedge clk); w++; end
    chk(w == RSTC, "R8 chip reset length", w, RSTC);
    chk(!busy, "R8 busy falls after reset pulse", busy, 0);
    chk(ovr == exp_ovr, "R7 overrun flag", ovr, exp_ovr);
    repeat (4) @(negedge clk);
    chk(!busy && !valid && !hold, "R9 idle after frame, no new frame",
        {busy, valid, hold}, 0);
    chk(ovr == exp_ovr, "R7 overrun held while idle", ovr, exp_ovr);
  endtask

  initial begin
    t_reset();
    run_frame(1'b0, -1, 0, 1'b0, 1'b0);
    run_frame(1'b1, NVAL - 1, BUDGET - NVAL * SLOT, 1'b0, 1'b0);
    run_frame(1'b0, NVAL - 1, BUDGET - NVAL * SLOT + 1, 1'b0, 1'b1);
    run_frame(1'b1, 4, 2, 1'b1, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule